// File: doc/BRIEF.md
# SD Host Slot Interrupt Combiner

This block holds the interrupt status of one SD host slot and folds it into a single level-sensitive interrupt line. Event pulses come from the command, DMA and card-detect logic. Each pulse is latched into a normal or an error status register, but only where the matching status-enable bit allows it. Software clears latched bits by writing ones to them. A separate pair of signal-enable masks, together with a two-bit wakeup control, decides which latched bits reach the line.

The slot interrupt status that software reads is not a stored flag. It is the same combinational expression that drives the line, so the readback and the pin cannot disagree. The normal status register also shows an error-summary bit. That bit is derived from the error status register and is never stored.

All registers are reached through a small synchronous write port with a combinational read port. The register index is 3 bits and the data is 16 bits wide.

Top module: `sdslot_irq_top`

## Requirements
- R1: Register map by index: 0 normal status, 1 error status, 2 normal status-enable, 3 error status-enable, 4 normal signal-enable, 5 error signal-enable, 6 wakeup control, 7 slot interrupt status. `irq_o` is high whenever a readable normal status bit and the same bit of the normal signal-enable are both 1.
- R2: `irq_o` is high whenever an error status bit and the same bit of the error signal-enable are both 1.
- R3: A `card_ins` pulse sets normal status bit 6 when status-enable bit 6 is set. When that bit is 1 and wakeup bit 0 is 1, `irq_o` is high even with signal-enable bit 6 clear.
- R4: A `card_rem` pulse sets normal status bit 7 when status-enable bit 7 is set. When that bit is 1 and wakeup bit 1 is 1, `irq_o` is high. Wakeup bit 0 does not gate the remove bit.
- R5: Reading index 7 returns `irq_o` in bit 0 and zeros elsewhere, in the same cycle the line changes. The wakeup register reads back its two bits with zeros above.
- R6: Normal status bit 15 reads 1 exactly while any error status bit is 1, and it clears by itself when they are all 0. Neither writes nor event pulses store anything in bit 15.
- R7: An event pulse sets a status bit only if that bit's status-enable is 1; otherwise it has no effect. Signal-enable never changes which bits are latched.
- R8: Status registers are write-one-to-clear, and writing 0 leaves a bit unchanged. The line drops in the cycle after the write that clears the last contributing bit. An event and a clear on the same bit in the same cycle leave the bit set.
- R9: A synchronous active-low reset clears every status, enable and wakeup register, so `irq_o` is low after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for read and write |
| reg_wdata | input | 16 | Write data (ones clear status bits) |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| norm_evt | input | 16 | Normal event pulses, one per status bit |
| err_evt | input | 16 | Error event pulses, one per status bit |
| card_ins | input | 1 | Card inserted pulse |
| card_rem | input | 1 | Card removed pulse |
| irq_o | output | 1 | Level interrupt line |

## Verification
The embedded properties assume that event pulses and register writes are sampled only on clock edges with reset high. They also assume that `reg_wdata` is meaningful only while `reg_we` is high. The stimulus honours this: every input changes one time unit after a rising edge, and inputs return to idle before each read. Events are held for exactly one cycle, so no single pulse is counted twice. Sequences deliberately overlap a clear with a set on the same bit, send events with their enables off, and reset in the middle of a run with the line high.

// File: rtl/sdslot_pkg.sv
// Shared constants for the SD slot interrupt combiner.
// Assumes a 16-bit register file indexed by a 3-bit address.
package sdslot_pkg;
    localparam int unsigned SD_DW  = 16;
    localparam int unsigned SD_AW  = 3;
    localparam int unsigned WAKE_W = 2;

    localparam logic [SD_AW-1:0] RA_NSTS = 3'd0;
    localparam logic [SD_AW-1:0] RA_ESTS = 3'd1;
    localparam logic [SD_AW-1:0] RA_NSEN = 3'd2;
    localparam logic [SD_AW-1:0] RA_ESEN = 3'd3;
    localparam logic [SD_AW-1:0] RA_NSIG = 3'd4;
    localparam logic [SD_AW-1:0] RA_ESIG = 3'd5;
    localparam logic [SD_AW-1:0] RA_WAKE = 3'd6;
    localparam logic [SD_AW-1:0] RA_SLOT = 3'd7;

    localparam int unsigned MASK_REGS = 4;
endpackage

// File: rtl/sdslot_status_reg.sv
// Write-one-to-clear status register with per-bit set gating.
// A bit is set by an event pulse only when its status-enable is 1.
// A set on a bit wins over a clear of that bit in the same cycle.
// Bits outside KEEP_MASK are never stored and always read 0.
// Assumes that event pulses are synchronous to clk.
module sdslot_status_reg #(
    parameter int unsigned W = 16,
    parameter logic [W-1:0] KEEP_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_we,
    input  logic [W-1:0] clr_data,
    input  logic [W-1:0] set_evt,
    input  logic [W-1:0] set_en,
    output logic [W-1:0] sts_o
);
    logic [W-1:0] sts_q;
    logic [W-1:0] set_vec;
    logic [W-1:0] clr_vec;

    // Gate the event pulses with status-enable and the storable-bit mask.
    always_comb set_vec = set_evt & set_en & KEEP_MASK;

    // The clear mask applies only while this register is being written.
    always_comb clr_vec = clr_we ? clr_data : '0;

    // Update the status bits; a set has priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= ((sts_q & ~clr_vec) | set_vec) & KEEP_MASK;
    end

    assign sts_o = sts_q;

    // R7
    set_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_evt & set_en & KEEP_MASK)) |=>
        ((sts_o & $past(set_evt & set_en & KEEP_MASK)) == $past(set_evt & set_en & KEEP_MASK)));

    // R7
    no_set_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_we && ((set_evt & set_en & KEEP_MASK) == '0)) |=> (sts_o == $past(sts_o)));

    // R8
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && ((set_evt & set_en) == '0)) |=> ((sts_o & $past(clr_data)) == '0));
endmodule

// File: rtl/sdslot_cfg_regs.sv
// Enable-mask and wakeup-control registers of the slot interrupt combiner.
// Four full-width masks sit at consecutive indices from RA_NSEN upward,
// in this order: normal status-enable, error status-enable, normal
// signal-enable, error signal-enable. The wakeup control holds two bits.
// Assumes that reg_wdata is meaningful only while reg_we is high.
module sdslot_cfg_regs
    import sdslot_pkg::*;
#(
    parameter int unsigned W = SD_DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SD_AW-1:0]  addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      nsen_o,
    output logic [W-1:0]      esen_o,
    output logic [W-1:0]      nsig_o,
    output logic [W-1:0]      esig_o,
    output logic [WAKE_W-1:0] wake_o
);
    logic [W-1:0]      mask_q [MASK_REGS];
    logic [WAKE_W-1:0] wake_q;

    for (genvar g = 0; g < MASK_REGS; g++) begin : g_mask
        localparam logic [SD_AW-1:0] MY_ADDR = RA_NSEN + SD_AW'(g);
        // Load one mask register when its own index is written.
        always_ff @(posedge clk) begin
            if (!rst_n)                        mask_q[g] <= '0;
            else if (we && (addr == MY_ADDR))  mask_q[g] <= wdata;
        end
    end

    // Load the wakeup control bits.
    always_ff @(posedge clk) begin
        if (!rst_n)                        wake_q <= '0;
        else if (we && (addr == RA_WAKE))  wake_q <= wdata[WAKE_W-1:0];
    end

    assign nsen_o = mask_q[0];
    assign esen_o = mask_q[1];
    assign nsig_o = mask_q[2];
    assign esig_o = mask_q[3];
    assign wake_o = wake_q;
endmodule

// File: rtl/sdslot_irq_combine.sv
// Combinational interrupt combiner. The line is the OR of four terms:
// normal status masked by normal signal-enable, error status masked by
// error signal-enable, the card-insert bit gated by wakeup bit 0, and the
// card-remove bit gated by wakeup bit 1. Nothing is stored here.
module sdslot_irq_combine
    import sdslot_pkg::*;
#(
    parameter int unsigned W       = SD_DW,
    parameter int unsigned INS_BIT = 6,
    parameter int unsigned REM_BIT = 7
) (
    input  logic [W-1:0]      nsts_view,
    input  logic [W-1:0]      ests,
    input  logic [W-1:0]      nsig,
    input  logic [W-1:0]      esig,
    input  logic [WAKE_W-1:0] wake,
    output logic              line_o
);
    logic              norm_hit;
    logic              err_hit;
    logic [WAKE_W-1:0] card_bits;
    logic              wake_hit;

    // Evaluate each contributing term, then OR them into the line.
    always_comb begin
        norm_hit  = |(nsts_view & nsig);
        err_hit   = |(ests & esig);
        card_bits = {nsts_view[REM_BIT], nsts_view[INS_BIT]};
        wake_hit  = |(card_bits & wake);
        line_o    = norm_hit | err_hit | wake_hit;
    end
endmodule

// File: rtl/sdslot_irq_top.sv
// SD slot interrupt combiner top.
// Holds the normal and error status registers and the enable/wakeup
// registers. It derives the error-summary bit and drives a level interrupt
// line that also serves as the slot interrupt status readback.
// Assumes a single clock and a synchronous active-low reset, and that
// events are one-cycle pulses sampled on clk.
module sdslot_irq_top
    import sdslot_pkg::*;
#(
    parameter int unsigned DATA_W  = SD_DW,
    parameter int unsigned INS_BIT = 6,
    parameter int unsigned REM_BIT = 7,
    parameter int unsigned SUM_BIT = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [SD_AW-1:0]  reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] norm_evt,
    input  logic [DATA_W-1:0] err_evt,
    input  logic              card_ins,
    input  logic              card_rem,
    output logic              irq_o
);
    localparam logic [DATA_W-1:0] SUM_MASK = DATA_W'(1) << SUM_BIT;
    localparam logic [DATA_W-1:0] INS_MASK = DATA_W'(1) << INS_BIT;
    localparam logic [DATA_W-1:0] REM_MASK = DATA_W'(1) << REM_BIT;

    logic [DATA_W-1:0] nsts_q, ests_q, nsts_view;
    logic [DATA_W-1:0] nsen, esen, nsig, esig;
    logic [WAKE_W-1:0] wake;
    logic [DATA_W-1:0] norm_set;
    logic              nsts_wr, ests_wr, err_any;

    // Merge the card-detect pulses into the normal event vector.
    always_comb begin
        norm_set = norm_evt;
        if (card_ins) norm_set = norm_set | INS_MASK;
        if (card_rem) norm_set = norm_set | REM_MASK;
    end

    // Decode writes aimed at the two status registers.
    always_comb begin
        nsts_wr = reg_we && (reg_addr == RA_NSTS);
        ests_wr = reg_we && (reg_addr == RA_ESTS);
    end

    sdslot_status_reg #(.W(DATA_W), .KEEP_MASK(~SUM_MASK)) u_norm_sts (
        .clk(clk), .rst_n(rst_n), .clr_we(nsts_wr), .clr_data(reg_wdata),
        .set_evt(norm_set), .set_en(nsen), .sts_o(nsts_q)
    );

    sdslot_status_reg #(.W(DATA_W), .KEEP_MASK('1)) u_err_sts (
        .clk(clk), .rst_n(rst_n), .clr_we(ests_wr), .clr_data(reg_wdata),
        .set_evt(err_evt), .set_en(esen), .sts_o(ests_q)
    );

    sdslot_cfg_regs #(.W(DATA_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .nsen_o(nsen), .esen_o(esen),
        .nsig_o(nsig), .esig_o(esig), .wake_o(wake)
    );

    // Insert the derived error-summary bit into the normal status view.
    always_comb begin
        err_any   = |ests_q;
        nsts_view = (nsts_q & ~SUM_MASK) | (err_any ? SUM_MASK : '0);
    end

    sdslot_irq_combine #(.W(DATA_W), .INS_BIT(INS_BIT), .REM_BIT(REM_BIT)) u_comb (
        .nsts_view(nsts_view), .ests(ests_q), .nsig(nsig), .esig(esig),
        .wake(wake), .line_o(irq_o)
    );

    // Select the read data for the addressed register.
    always_comb begin
        case (reg_addr)
            RA_NSTS: reg_rdata = nsts_view;
            RA_ESTS: reg_rdata = ests_q;
            RA_NSEN: reg_rdata = nsen;
            RA_ESEN: reg_rdata = esen;
            RA_NSIG: reg_rdata = nsig;
            RA_ESIG: reg_rdata = esig;
            RA_WAKE: reg_rdata = {{(DATA_W-WAKE_W){1'b0}}, wake};
            default: reg_rdata = {{(DATA_W-1){1'b0}}, irq_o};
        endcase
    end

    // R5
    slot_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == RA_SLOT) |-> (reg_rdata == {{(DATA_W-1){1'b0}}, irq_o}));

    // R3
    wake_ins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nsts_q[INS_BIT] && wake[0]) |-> irq_o);

    // R4
    wake_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nsts_q[REM_BIT] && wake[1]) |-> irq_o);

    // R2
    err_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ests_q & esig) != '0) |-> irq_o);

    // R6
    sum_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == RA_NSTS) |-> (reg_rdata[SUM_BIT] == (ests_q != '0)));
endmodule

// File: tb/sdslot_irq_top_tb_top.sv
// Scoreboard bench: the driver updates a reference model and queues the
// expected readback; a negedge monitor pops and compares it.
module sdslot_irq_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [15:0] norm_evt = '0;
    logic [15:0] err_evt = '0;
    logic        card_ins = 1'b0;
    logic        card_rem = 1'b0;
    logic        irq_o;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sdslot_irq_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .norm_evt(norm_evt),
        .err_evt(err_evt), .card_ins(card_ins), .card_rem(card_rem), .irq_o(irq_o)
    );

    // reference model
    logic [15:0] m_n, m_e, m_nsen, m_esen, m_nsig, m_esig;
    logic [1:0]  m_wk;

    function automatic logic [15:0] m_nview();
        return {|m_e, m_n[14:0]};
    endfunction

    function automatic logic m_line();
        logic [15:0] v;
        v = m_nview();
        return (|(v & m_nsig)) | (|(m_e & m_esig)) |
               (v[6] & m_wk[0]) | (v[7] & m_wk[1]);
    endfunction

    function automatic logic [15:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return m_nview();
            3'd1: return m_e;
            3'd2: return m_nsen;
            3'd3: return m_esen;
            3'd4: return m_nsig;
            3'd5: return m_esig;
            3'd6: return {14'd0, m_wk};
            default: return {15'd0, m_line()};
        endcase
    endfunction

    typedef struct {
        logic [2:0]  a;
        logic [15:0] d;
        logic        i;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    // monitor: compare queued expectations away from the active edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_vec++;
            if (reg_rdata !== e.d || irq_o !== e.i) begin
                n_bad++;
                $display("FAIL %s: addr %0d rdata=%h irq=%b expected rdata=%h irq=%b",
                         e.tag, e.a, reg_rdata, irq_o, e.d, e.i);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: cycles=%0d expected below 20000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic model_reset();
        m_n = '0; m_e = '0; m_nsen = '0; m_esen = '0;
        m_nsig = '0; m_esig = '0; m_wk = '0;
    endtask

    // one cycle of write and/or events, then the model follows the edge
    task automatic step(input logic we, input logic [2:0] a, input logic [15:0] wd,
                        input logic [15:0] ne, input logic [15:0] ee,
                        input logic ins, input logic rem);
        logic [15:0] nset, eset, nclr, eclr;
        @(posedge clk); #1;
        reg_we = we; reg_addr = a; reg_wdata = wd;
        norm_evt = ne; err_evt = ee; card_ins = ins; card_rem = rem;
        @(posedge clk); #1;
        nset = (ne | (ins ? 16'h0040 : 16'h0) | (rem ? 16'h0080 : 16'h0)) & m_nsen & 16'h7FFF;
        eset = ee & m_esen;
        nclr = (we && a == 3'd0) ? wd : 16'h0;
        eclr = (we && a == 3'd1) ? wd : 16'h0;
        m_n = ((m_n & ~nclr) | nset) & 16'h7FFF;
        m_e = (m_e & ~eclr) | eset;
        if (we) begin
            case (a)
                3'd2: m_nsen = wd;
                3'd3: m_esen = wd;
                3'd4: m_nsig = wd;
                3'd5: m_esig = wd;
                3'd6: m_wk = wd[1:0];
                default: ;
            endcase
        end
        reg_we = 1'b0; reg_wdata = '0; norm_evt = '0; err_evt = '0;
        card_ins = 1'b0; card_rem = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        step(1'b1, a, d, '0, '0, 1'b0, 1'b0);
    endtask

    task automatic ev(input logic [15:0] ne, input logic [15:0] ee,
                      input logic ins, input logic rem);
        step(1'b0, 3'd0, '0, ne, ee, ins, rem);
    endtask

    // driver: queue an expectation for one register and wait for the monitor
    task automatic chk(input logic [2:0] a, input string tag);
        exp_t e;
        reg_addr = a;
        e.a = a; e.d = m_read(a); e.i = m_line(); e.tag = tag;
        sb_q.push_back(e);
        wait (sb_q.size() == 0);
        @(posedge clk); #1;
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R9 reset state of every register
        for (int a = 0; a < 8; a++) chk(3'(a), "R9 reset state");
        // R7 event with status-enable off is ignored
        ev(16'h0001, 16'h0001, 1'b1, 1'b1);
        chk(3'd0, "R7 disabled normal event");
        chk(3'd1, "R7 disabled error event");
        // R7 enabled event latches, signal-enable off keeps line low
        wr(3'd2, 16'h0001);
        ev(16'h0001, '0, 1'b0, 1'b0);
        chk(3'd0, "R7 latched with signal off");
        // R1 signal-enable propagates, R5 slot readback
        wr(3'd4, 16'h0001);
        chk(3'd0, "R1 normal line");
        chk(3'd7, "R5 slot readback high");
        // R8 write zero keeps, write one clears
        wr(3'd0, 16'h0000);
        chk(3'd0, "R8 write zero keeps");
        wr(3'd0, 16'h0001);
        chk(3'd7, "R8 clear drops line");
        // R6 / R2 error path
        wr(3'd3, 16'h0004);
        ev('0, 16'h0004, 1'b0, 1'b0);
        chk(3'd0, "R6 summary set");
        chk(3'd1, "R2 error latched, signal off");
        wr(3'd5, 16'h0004);
        chk(3'd7, "R2 error line");
        wr(3'd5, 16'h0000);
        wr(3'd4, 16'h8001);
        chk(3'd7, "R6 summary via normal signal");
        wr(3'd1, 16'h0004);
        chk(3'd0, "R6 summary self-clears");
        chk(3'd7, "R6 line low after error clear");
        // R6 bit 15 not storable
        wr(3'd2, 16'h8001);
        ev(16'h8000, '0, 1'b0, 1'b0);
        chk(3'd0, "R6 event on bit 15 ignored");
        // R3 card insert with wakeup
        wr(3'd4, 16'h0000);
        wr(3'd2, 16'h00C0);
        ev('0, '0, 1'b1, 1'b0);
        chk(3'd0, "R3 insert latched, line low");
        wr(3'd6, 16'h0001);
        chk(3'd7, "R3 wake on insert");
        chk(3'd6, "R5 wakeup readback");
        wr(3'd0, 16'h0040);
        chk(3'd7, "R3 insert cleared");
        // R4 remove not gated by wakeup bit 0
        ev('0, '0, 1'b0, 1'b1);
        chk(3'd7, "R4 remove needs wake bit 1");
        wr(3'd6, 16'h0002);
        chk(3'd7, "R4 wake on remove");
        wr(3'd0, 16'h0080);
        chk(3'd7, "R4 remove cleared");
        // R8 set wins over simultaneous clear
        wr(3'd2, 16'h00FF);
        ev(16'h0010, '0, 1'b0, 1'b0);
        step(1'b1, 3'd0, 16'h0010, 16'h0010, '0, 1'b0, 1'b0);
        chk(3'd0, "R8 set beats clear");
        // R1 multi-bit pattern with partial enables
        wr(3'd4, 16'hFFFF);
        ev(16'h0A0A, '0, 1'b0, 1'b0);
        chk(3'd0, "R1 pattern latched");
        chk(3'd7, "R1 pattern line");
        wr(3'd0, 16'h001A);
        chk(3'd7, "R8 clear all drops line");
        // R9 reset in the middle of activity
        ev(16'h0003, '0, 1'b0, 1'b0);
        @(posedge clk); #1 rst_n = 1'b0;
        model_reset();
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        chk(3'd0, "R9 mid-run reset status");
        chk(3'd4, "R9 mid-run reset signal-enable");
        chk(3'd7, "R9 mid-run reset line");
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule